// File: doc/BRIEF.md
# Segmented Address Extension Unit

This block turns a 16-bit logical address from a CPU into a 22-bit physical address. Data accesses are paged. The top two logical address bits pick one of four 8-bit page registers, and that register takes the place of those two bits. Code fetches, interrupt-context fetches and DMA transfers are segmented instead. A 6-bit segment register is placed above the full 16-bit logical address.

Software reaches the seven translation registers and two control bits through a register-file port. The port carries a page number, a register number, a write strobe and data, and returns read data combinationally. Page 21 (0x15) is the dedicated page that holds all nine fields. A remap bit also makes the four page registers visible at registers 240 to 243 of every page, so data paging can be changed without switching page. The translation is combinational from the current register contents, and register writes land on the clock edge.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, all four page registers, all three segment registers and both control bits read as 0.
- R2: For a data access (`acc_kind_i` = 1), `pa_o` = {page register n, `la_i[13:0]`}, where n = `la_i[15:14]`.
- R3: For a code access (`acc_kind_i` = 0), `pa_o` = {code segment, `la_i[15:0]`}.
- R4: For an interrupt-context access (`acc_kind_i` = 2), the segment is the interrupt segment when the select bit is 0 and the code segment when it is 1.
- R5: For a DMA access (`acc_kind_i` = 3), the segment is the DMA segment when the select bit is 0 and the interrupt segment when it is 1.
- R6: In page 21, the register map is as follows. Registers 240 to 243 are page registers 0 to 3. Register 244 is control, with bit 0 as the segment select bit and bit 1 as the remap bit. Registers 245, 246 and 247 are the code, interrupt and DMA segments. Segment writes keep `wdata[5:0]`, and reads return the stored bits zero-extended.
- R7: With remap at 0, registers 240 to 243 of any page other than 21 are unmapped. Writes to them change no page register, and `rf_hit_o` is 0 there.
- R8: With remap at 1, the page registers can be read and written at 240 to 243 of every page. The segment and control registers stay reachable only in page 21.
- R9: A write changes the translation starting at the clock edge that takes it. Before that edge, the old value is still in use.
- R10: An address that maps to no register returns `rf_rdata_o` = 0 and `rf_hit_o` = 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| la_i | input | 16 | Logical address |
| acc_kind_i | input | 2 | Access type: 0 code, 1 data, 2 interrupt, 3 DMA |
| rf_we_i | input | 1 | Register-file write strobe |
| rf_page_i | input | 6 | Current register-file page |
| rf_addr_i | input | 8 | Register number |
| rf_wdata_i | input | 8 | Write data |
| rf_rdata_o | output | 8 | Read data, combinational |
| rf_hit_o | output | 1 | Address maps to a register of this unit |
| pa_o | output | 22 | Physical address |

## Verification
`pa_o`, `rf_rdata_o` and `rf_hit_o` are combinational, so they are due in the same cycle as the address and page inputs. A register write becomes visible one clock edge after the strobe. The bench drives inputs on the falling edge and samples 1 ns later, well before the next rising edge. For R9, it samples once inside the write cycle, where the old value is expected, and once after the taking edge, where the new value is expected.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LA_W     = 16;
  localparam int PG_W     = 8;
  localparam int SEG_W    = 6;
  localparam int NUM_PG   = 4;
  localparam int IDX_W    = $clog2(NUM_PG);
  localparam int OFF_W    = LA_W - IDX_W;
  localparam int PA_W     = SEG_W + LA_W;
  localparam int RF_AW    = 8;
  localparam int RF_DW    = 8;
  localparam int RFP_W    = 6;
  localparam logic [RFP_W-1:0] DED_PAGE = 6'd21;
  localparam logic [RF_AW-1:0] BASE_REG = 8'd240;
  localparam logic [RF_AW-1:0] CTL_REG  = BASE_REG + 8'(NUM_PG);
  localparam logic [RF_AW-1:0] CSR_REG  = CTL_REG + 8'd1;
  localparam logic [RF_AW-1:0] ISR_REG  = CTL_REG + 8'd2;
  localparam logic [RF_AW-1:0] DSR_REG  = CTL_REG + 8'd3;

  typedef enum logic [1:0] {
    ACC_CODE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_INTR = 2'd2,
    ACC_DMA  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs
  import seg_xlate_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [RFP_W-1:0]            page_i,
  input  logic [RF_AW-1:0]            addr_i,
  input  logic [RF_DW-1:0]            wdata_i,
  output logic [RF_DW-1:0]            rdata_o,
  output logic                        hit_o,
  output logic [NUM_PG-1:0][PG_W-1:0] dpr_o,
  output logic [SEG_W-1:0]            csr_o,
  output logic [SEG_W-1:0]            isr_o,
  output logic [SEG_W-1:0]            dsr_o,
  output logic                        alt_o,
  output logic                        remap_o
);
  logic             in_ded;
  logic [RF_AW-1:0] off;
  logic             dpr_hit, ctl_hit, csr_hit, isr_hit, dsr_hit;
  logic [IDX_W-1:0] idx;

  assign in_ded  = (page_i == DED_PAGE);
  assign off     = addr_i - BASE_REG;
  assign idx     = off[IDX_W-1:0];
  // page registers: dedicated page, or any page once remapped
  assign dpr_hit = (off < RF_AW'(NUM_PG)) && (in_ded || remap_o);
  assign ctl_hit = in_ded && (addr_i == CTL_REG);
  assign csr_hit = in_ded && (addr_i == CSR_REG);
  assign isr_hit = in_ded && (addr_i == ISR_REG);
  assign dsr_hit = in_ded && (addr_i == DSR_REG);
  assign hit_o   = dpr_hit | ctl_hit | csr_hit | isr_hit | dsr_hit;

  for (genvar g = 0; g < NUM_PG; g++) begin : g_dpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dpr_o[g] <= '0;
      else if (we_i && dpr_hit && (idx == IDX_W'(g))) dpr_o[g] <= wdata_i[PG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_o   <= '0;
      isr_o   <= '0;
      dsr_o   <= '0;
      alt_o   <= 1'b0;
      remap_o <= 1'b0;
    end else if (we_i) begin
      if (csr_hit) csr_o <= wdata_i[SEG_W-1:0];
      if (isr_hit) isr_o <= wdata_i[SEG_W-1:0];
      if (dsr_hit) dsr_o <= wdata_i[SEG_W-1:0];
      if (ctl_hit) begin
        alt_o   <= wdata_i[0];
        remap_o <= wdata_i[1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dpr_hit)      rdata_o = RF_DW'(dpr_o[idx]);
    else if (ctl_hit) rdata_o = RF_DW'({remap_o, alt_o});
    else if (csr_hit) rdata_o = RF_DW'(csr_o);
    else if (isr_hit) rdata_o = RF_DW'(isr_o);
    else if (dsr_hit) rdata_o = RF_DW'(dsr_o);
  end
endmodule

// File: rtl/seg_xlate_map.sv
module seg_xlate_map
  import seg_xlate_pkg::*;
(
  input  logic [LA_W-1:0]             la_i,
  input  acc_kind_e                   kind_i,
  input  logic [NUM_PG-1:0][PG_W-1:0] dpr_i,
  input  logic [SEG_W-1:0]            csr_i,
  input  logic [SEG_W-1:0]            isr_i,
  input  logic [SEG_W-1:0]            dsr_i,
  input  logic                        alt_i,
  output logic [PA_W-1:0]             pa_o
);
  logic [SEG_W-1:0] seg;
  logic [IDX_W-1:0] pg_sel;

  assign pg_sel = la_i[LA_W-1:OFF_W];

  always_comb begin
    unique case (kind_i)
      ACC_INTR: seg = alt_i ? csr_i : isr_i;
      ACC_DMA:  seg = alt_i ? isr_i : dsr_i;
      default:  seg = csr_i;
    endcase
    if (kind_i == ACC_DATA) pa_o = {dpr_i[pg_sel], la_i[OFF_W-1:0]};
    else                    pa_o = {seg, la_i};
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LA_W-1:0]   la_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              rf_we_i,
  input  logic [RFP_W-1:0]  rf_page_i,
  input  logic [RF_AW-1:0]  rf_addr_i,
  input  logic [RF_DW-1:0]  rf_wdata_i,
  output logic [RF_DW-1:0]  rf_rdata_o,
  output logic              rf_hit_o,
  output logic [PA_W-1:0]   pa_o
);
  logic [NUM_PG-1:0][PG_W-1:0] dpr_w;
  logic [SEG_W-1:0]            csr_w, isr_w, dsr_w;
  logic                        alt_w, remap_w;

  seg_xlate_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_i),
    .page_i  (rf_page_i),
    .addr_i  (rf_addr_i),
    .wdata_i (rf_wdata_i),
    .rdata_o (rf_rdata_o),
    .hit_o   (rf_hit_o),
    .dpr_o   (dpr_w),
    .csr_o   (csr_w),
    .isr_o   (isr_w),
    .dsr_o   (dsr_w),
    .alt_o   (alt_w),
    .remap_o (remap_w)
  );

  seg_xlate_map u_map (
    .la_i   (la_i),
    .kind_i (acc_kind_e'(acc_kind_i)),
    .dpr_i  (dpr_w),
    .csr_i  (csr_w),
    .isr_i  (isr_w),
    .dsr_i  (dsr_w),
    .alt_i  (alt_w),
    .pa_o   (pa_o)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [LA_W-1:0]             la_i,
  input logic [1:0]                  acc_kind_i,
  input logic                        rf_we_i,
  input logic [RFP_W-1:0]            rf_page_i,
  input logic [RF_AW-1:0]            rf_addr_i,
  input logic [RF_DW-1:0]            rf_wdata_i,
  input logic                        rf_hit_o,
  input logic [PA_W-1:0]             pa_o,
  input logic [NUM_PG-1:0][PG_W-1:0] dpr_w,
  input logic [SEG_W-1:0]            csr_w,
  input logic [SEG_W-1:0]            isr_w,
  input logic [SEG_W-1:0]            dsr_w,
  input logic                        alt_w,
  input logic                        remap_w
);
  assert_data_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_kind_i == 2'd1 |-> pa_o[OFF_W-1:0] == la_i[OFF_W-1:0]);

  assert_data_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_kind_i == 2'd1 |-> pa_o[PA_W-1:OFF_W] == dpr_w[la_i[LA_W-1:OFF_W]]);

  assert_code_seg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_kind_i == 2'd0 |-> pa_o == {csr_w, la_i});

  assert_intr_seg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_kind_i == 2'd2 |-> pa_o[PA_W-1:LA_W] == (alt_w ? csr_w : isr_w));

  assert_dma_seg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_kind_i == 2'd3 |-> pa_o[PA_W-1:LA_W] == (alt_w ? isr_w : dsr_w));

  assert_hidden_pages_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!remap_w && rf_page_i != DED_PAGE && rf_addr_i >= BASE_REG &&
     rf_addr_i < CTL_REG) |-> !rf_hit_o);

  assert_no_stray_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_hit_o |=> ($stable(dpr_w) && $stable(csr_w) && $stable(isr_w) &&
                   $stable(dsr_w) && $stable(alt_w) && $stable(remap_w)));

  assert_csr_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_i && rf_page_i == DED_PAGE && rf_addr_i == CSR_REG)
      |=> csr_w == $past(rf_wdata_i[SEG_W-1:0]));
endmodule

bind seg_xlate_top seg_xlate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .la_i       (la_i),
  .acc_kind_i (acc_kind_i),
  .rf_we_i    (rf_we_i),
  .rf_page_i  (rf_page_i),
  .rf_addr_i  (rf_addr_i),
  .rf_wdata_i (rf_wdata_i),
  .rf_hit_o   (rf_hit_o),
  .pa_o       (pa_o),
  .dpr_w      (dpr_w),
  .csr_w      (csr_w),
  .isr_w      (isr_w),
  .dsr_w      (dsr_w),
  .alt_w      (alt_w),
  .remap_w    (remap_w)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] la_i = '0;
  logic [1:0]  acc_kind_i = '0;
  logic        rf_we_i = 1'b0;
  logic [5:0]  rf_page_i = '0;
  logic [7:0]  rf_addr_i = '0;
  logic [7:0]  rf_wdata_i = '0;
  logic [7:0]  rf_rdata_o;
  logic        rf_hit_o;
  logic [21:0] pa_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_xlate_top dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] pg, logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    rf_we_i = 1'b1; rf_page_i = pg; rf_addr_i = a; rf_wdata_i = d;
    @(negedge clk_i);
    rf_we_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] pg, logic [7:0] a, output logic [7:0] d, output logic h);
    @(negedge clk_i);
    rf_page_i = pg; rf_addr_i = a;
    #1;
    d = rf_rdata_o; h = rf_hit_o;
  endtask

  task automatic xl(logic [1:0] k, logic [15:0] la, output logic [21:0] pa);
    @(negedge clk_i);
    acc_kind_i = k; la_i = la;
    #1;
    pa = pa_o;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic h; logic [21:0] pa;
    for (int a = 240; a < 248; a++) begin
      rd(6'd21, 8'(a), d, h);
      check("R1 reset value", {24'd0, d}, 32'd0);
    end
    xl(2'd0, 16'h1234, pa);
    check("R1 reset code pa", {10'd0, pa}, 32'h001234);
  endtask

  task automatic t_regmap();
    logic [7:0] d; logic h;
    wr(6'd21, 8'd245, 8'hFF);
    rd(6'd21, 8'd245, d, h);
    check("R6 code seg 6-bit", {24'd0, d}, 32'h3F);
    check("R6 code seg hit", {31'd0, h}, 32'd1);
    wr(6'd21, 8'd246, 8'hD5);
    rd(6'd21, 8'd246, d, h);
    check("R6 intr seg", {24'd0, d}, 32'h15);
    wr(6'd21, 8'd247, 8'h33);
    rd(6'd21, 8'd247, d, h);
    check("R6 dma seg", {24'd0, d}, 32'h33);
    wr(6'd21, 8'd244, 8'hFD);
    rd(6'd21, 8'd244, d, h);
    check("R6 control bits", {24'd0, d}, 32'h01);
    wr(6'd21, 8'd244, 8'h00);
    wr(6'd21, 8'd240, 8'h11);
    wr(6'd21, 8'd241, 8'h22);
    wr(6'd21, 8'd242, 8'hA5);
    wr(6'd21, 8'd243, 8'hFF);
    rd(6'd21, 8'd242, d, h);
    check("R6 page reg 2", {24'd0, d}, 32'hA5);
  endtask

  task automatic t_data();
    logic [21:0] pa;
    xl(2'd1, 16'h0000, pa);
    check("R2 data page0", {10'd0, pa}, 32'h11 << 14);
    xl(2'd1, 16'h7ABC, pa);
    check("R2 data page1", {10'd0, pa}, (32'h22 << 14) | 32'h3ABC);
    xl(2'd1, 16'h8001, pa);
    check("R2 data page2", {10'd0, pa}, (32'hA5 << 14) | 32'h0001);
    xl(2'd1, 16'hFFFF, pa);
    check("R2 data page3", {10'd0, pa}, 32'h3FFFFF);
  endtask

  task automatic t_code();
    logic [21:0] pa;
    wr(6'd21, 8'd245, 8'h2A);
    xl(2'd0, 16'hBEEF, pa);
    check("R3 code", {10'd0, pa}, 32'h2ABEEF);
  endtask

  task automatic t_intr_dma();
    logic [21:0] pa;
    xl(2'd2, 16'h0100, pa);
    check("R4 intr select=0", {10'd0, pa}, 32'h150100);
    xl(2'd3, 16'h0200, pa);
    check("R5 dma select=0", {10'd0, pa}, 32'h330200);
    wr(6'd21, 8'd244, 8'h01);
    xl(2'd2, 16'h0100, pa);
    check("R4 intr select=1", {10'd0, pa}, 32'h2A0100);
    xl(2'd3, 16'h0200, pa);
    check("R5 dma select=1", {10'd0, pa}, 32'h150200);
    wr(6'd21, 8'd244, 8'h00);
  endtask

  task automatic t_remap_off();
    logic [7:0] d; logic h;
    rd(6'd0, 8'd240, d, h);
    check("R7 hit off-page", {31'd0, h}, 32'd0);
    check("R7 rdata off-page", {24'd0, d}, 32'd0);
    wr(6'd0, 8'd240, 8'h77);
    rd(6'd21, 8'd240, d, h);
    check("R7 write ignored", {24'd0, d}, 32'h11);
  endtask

  task automatic t_remap_on();
    logic [7:0] d; logic h; logic [21:0] pa;
    wr(6'd21, 8'd244, 8'h02);
    wr(6'd3, 8'd241, 8'h5C);
    xl(2'd1, 16'h4000, pa);
    check("R8 remapped write", {10'd0, pa}, 32'h5C << 14);
    rd(6'd3, 8'd241, d, h);
    check("R8 remapped read", {23'd0, h, d}, 32'h15C);
    rd(6'd3, 8'd245, d, h);
    check("R8 seg not remapped", {31'd0, h}, 32'd0);
    wr(6'd3, 8'd245, 8'h01);
    rd(6'd21, 8'd245, d, h);
    check("R8 seg write off-page ignored", {24'd0, d}, 32'h2A);
    wr(6'd21, 8'd244, 8'h00);
  endtask

  task automatic t_timing();
    @(negedge clk_i);
    acc_kind_i = 2'd0; la_i = 16'h0042;
    rf_we_i = 1'b1; rf_page_i = 6'd21; rf_addr_i = 8'd245; rf_wdata_i = 8'h07;
    #1;
    check("R9 old value before edge", {10'd0, pa_o}, 32'h2A0042);
    @(negedge clk_i);
    rf_we_i = 1'b0;
    #1;
    check("R9 new value after edge", {10'd0, pa_o}, 32'h070042);
  endtask

  task automatic t_unmapped();
    logic [7:0] d; logic h; logic [21:0] pa;
    rd(6'd21, 8'd248, d, h);
    check("R10 reg 248", {23'd0, h, d}, 32'd0);
    rd(6'd21, 8'd239, d, h);
    check("R10 reg 239", {23'd0, h, d}, 32'd0);
    wr(6'd21, 8'd239, 8'h3F);
    xl(2'd0, 16'h0000, pa);
    check("R10 write ignored", {10'd0, pa}, 32'h070000);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regmap();
    t_data();
    t_code();
    t_intr_dma();
    t_remap_off();
    t_remap_on();
    t_timing();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule